// File: doc/BRIEF.md
# Serdes Loopback Diagnostic Controller

This block runs a self-test of a serialiser/deserialiser datapath with the cooperation of a host. While the test-enable level is held high, a sector-begin pulse opens an exchange of four byte strobes. During the first two strobes the host presents stimulus bytes, which the block captures. It then sends a preamble followed by both bytes through an internal serial loop. A parity checker watches the serial stream. A receiver hunts for the preamble, rebuilds the two bytes and checks their parity again.

During the last two strobes the block returns the rebuilt bytes to the host. Their parity bit is deliberately wrong, so that a third checker on the return path always reports an error and proves it can. The host reads the pulse outputs to judge the datapath. The two loop checkers stay quiet for clean stimulus and report when a stimulus byte carries bad parity. The preamble indication shows that the receiver locked. Dropping test-enable abandons the exchange at once.

Top module: `sdlb_diag`

## Requirements
- R1: While reset is asserted and after it is released with no stimulus, every output (byte_stb_o, resp_byte_o and the four pulse outputs) is zero.
- R2: An exchange starts only when sector_begin is high at a clock edge while test_en is high; a sector_begin seen while test_en is low produces no strobe.
- R3: An accepted sector_begin yields exactly four one-cycle strobes, with byte_stb_o bit k marking strobe k+1. The first strobe is in the cycle after the accepting edge and the rest follow every STB_GAP cycles (STB_GAP must be at least PRE_LEN + 2*(DATA_W+1) + 4). At most one bit is high at a time.
- R4: A byte is DATA_W data bits in bits [DATA_W-1:0] with an odd-parity bit in bit DATA_W. host_byte_i is captured only at the edge ending strobe 1 (first stimulus) and strobe 2 (second stimulus); its value at any other time has no effect.
- R5: resp_byte_o carries the looped-back first stimulus data during strobe 3 and the second during strobe 4. In both cases the parity bit is the XOR of the data bits, which is always wrong for odd parity. At all other times resp_byte_o is zero.
- R6: perr_fx_o pulses for one cycle in the cycle after strobe 3 and in the cycle after strobe 4, exactly twice per exchange.
- R7: perr_ser_o pulses exactly once, before strobe 3, when either stimulus byte has bad parity in the serial stream; otherwise it stays low for the exchange.
- R8: perr_des_o pulses exactly once, before strobe 3, when either deserialised byte has bad parity; otherwise it stays low for the exchange.
- R9: preamble_o pulses exactly once per exchange, between strobe 2 and strobe 3, when the receiver finds the preamble.
- R10: A sector_begin that arrives during a running exchange is ignored; the strobe schedule is unchanged and no second exchange follows.
- R11: When test_en is low, every output is zero in that same cycle. An exchange in progress is abandoned, and no strobe follows until a new sector_begin is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Diagnostic enable level |
| sector_begin | input | 1 | Start pulse for an exchange |
| host_byte_i | input | DATA_W+1 | Stimulus byte from host, parity in MSB |
| byte_stb_o | output | 4 | One-hot byte strobes 1 to 4 |
| resp_byte_o | output | DATA_W+1 | Response byte to host during strobes 3 and 4 |
| perr_ser_o | output | 1 | Parity fault seen in the serial stream |
| perr_des_o | output | 1 | Parity fault seen in the deserialised bytes |
| perr_fx_o | output | 1 | Forced parity fault seen on a response byte |
| preamble_o | output | 1 | Preamble found by the receiver |

## Verification
The bench sweeps all 256 values of the first stimulus byte. The second byte is derived from the first, and the four parity good/bad combinations rotate across the sweep. A design that swapped the two bytes, missed a serial bit or fixed the response parity would return a wrong byte on strobe 3 or 4. A checker that looked at the wrong bit group would pulse on clean stimulus or stay silent on bad stimulus. Between strobes the host drives junk, which exposes a capture that is not tied to the strobe. Further runs give a second sector_begin mid-exchange, which would shift the schedule in a design that restarts. They give a sector_begin with test-enable low, and they drop test-enable on strobe 3 and in mid-stream. A design that fails to flush its receiver on abort would then miss the preamble or return stale bytes in the next exchange.

// File: rtl/sdlb_pkg.sv
`timescale 1ns/1ps
package sdlb_pkg;

  // strobe sequencer state
  typedef enum logic {
    SEQ_IDLE,
    SEQ_RUN
  } seq_st_e;

  // receiver state
  typedef enum logic [1:0] {
    RX_HUNT,
    RX_DATA,
    RX_DONE
  } rx_st_e;

endpackage

// File: rtl/sdlb_rst_sync.sv
`timescale 1ns/1ps
module sdlb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/sdlb_strobe_seq.sv
`timescale 1ns/1ps
module sdlb_strobe_seq
  import sdlb_pkg::*;
#(
  parameter int STB_GAP = 48,
  parameter int NSTB    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            start,
  output logic [NSTB-1:0] stb_o
);

  localparam int CW = $clog2(STB_GAP + 1);
  localparam int IW = (NSTB > 1) ? $clog2(NSTB) : 1;

  seq_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          seq_en;
  logic          fire;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    if (!run) begin
      st_d  = SEQ_IDLE;
      cnt_d = '0;
      idx_d = '0;
    end else begin
      case (st_q)
        SEQ_IDLE: begin
          if (start) begin
            st_d  = SEQ_RUN;
            cnt_d = '0;
            idx_d = '0;
          end
        end
        SEQ_RUN: begin
          if (cnt_q == CW'(STB_GAP - 1)) begin
            cnt_d = '0;
            idx_d = idx_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
          if ((cnt_q == '0) && (idx_q == IW'(NSTB - 1))) begin
            st_d  = SEQ_IDLE;
            cnt_d = '0;
            idx_d = '0;
          end
        end
        default: st_d = SEQ_IDLE;
      endcase
    end
  end

  assign seq_en = run || (st_q != SEQ_IDLE) || (cnt_q != '0) || (idx_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
    end else if (seq_en) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  assign fire = run && (st_q == SEQ_RUN) && (cnt_q == '0);

  for (genvar k = 0; k < NSTB; k++) begin : g_stb
    assign stb_o[k] = fire && (idx_q == IW'(k));
  end

endmodule

// File: rtl/sdlb_ser_tx.sv
`timescale 1ns/1ps
module sdlb_ser_tx #(
  parameter int                DATA_W  = 8,
  parameter int                PRE_LEN = 8,
  parameter logic [PRE_LEN-1:0] PRE_PAT = 8'hB4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [DATA_W:0]   w1,
  input  logic [DATA_W:0]   w2,
  output logic              ser_vld,
  output logic              ser_bit,
  output logic              ser_pay
);

  localparam int W  = DATA_W + 1;
  localparam int SL = PRE_LEN + 2 * W;
  localparam int LW = $clog2(SL + 1);

  logic [SL-1:0] sreg_q, sreg_d;
  logic [LW-1:0] left_q, left_d;
  logic          tx_en;

  always_comb begin
    sreg_d = sreg_q;
    left_d = left_q;
    if (clr) begin
      sreg_d = '0;
      left_d = '0;
    end else if (load) begin
      sreg_d = {w2, w1, PRE_PAT};
      left_d = LW'(SL);
    end else if (left_q != '0) begin
      sreg_d = {1'b0, sreg_q[SL-1:1]};
      left_d = left_q - 1'b1;
    end
  end

  assign tx_en = clr || load || (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      left_q <= '0;
    end else if (tx_en) begin
      sreg_q <= sreg_d;
      left_q <= left_d;
    end
  end

  assign ser_vld = (left_q != '0);
  assign ser_bit = sreg_q[0];
  assign ser_pay = ser_vld && (left_q <= LW'(2 * W));

endmodule

// File: rtl/sdlb_ser_par.sv
`timescale 1ns/1ps
module sdlb_ser_par #(
  parameter int W  = 9,
  parameter int NW = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic vld,
  input  logic pay,
  input  logic bit_i,
  output logic err_pulse_o
);

  localparam int BW = $clog2(W);
  localparam int GW = (NW > 1) ? $clog2(NW) : 1;

  logic [BW-1:0] bc_q, bc_d;
  logic [GW-1:0] gc_q, gc_d;
  logic          acc_q, acc_d;
  logic          err_q, err_d;
  logic          pls_q, pls_d;
  logic          acc_n;
  logic          grp_bad;
  logic          par_en;

  always_comb begin
    bc_d    = bc_q;
    gc_d    = gc_q;
    acc_d   = acc_q;
    err_d   = err_q;
    pls_d   = 1'b0;
    acc_n   = acc_q ^ bit_i;
    grp_bad = ~acc_n;
    if (clr) begin
      bc_d  = '0;
      gc_d  = '0;
      acc_d = 1'b0;
      err_d = 1'b0;
    end else if (vld && pay) begin
      if (bc_q == BW'(W - 1)) begin
        bc_d  = '0;
        acc_d = 1'b0;
        if (gc_q == GW'(NW - 1)) begin
          gc_d  = '0;
          err_d = 1'b0;
          pls_d = err_q | grp_bad;
        end else begin
          gc_d  = gc_q + 1'b1;
          err_d = err_q | grp_bad;
        end
      end else begin
        bc_d  = bc_q + 1'b1;
        acc_d = acc_n;
      end
    end
  end

  assign par_en = clr || vld || pls_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_q  <= '0;
      gc_q  <= '0;
      acc_q <= 1'b0;
      err_q <= 1'b0;
      pls_q <= 1'b0;
    end else if (par_en) begin
      bc_q  <= bc_d;
      gc_q  <= gc_d;
      acc_q <= acc_d;
      err_q <= err_d;
      pls_q <= pls_d;
    end
  end

  assign err_pulse_o = pls_q;

endmodule

// File: rtl/sdlb_des_rx.sv
`timescale 1ns/1ps
module sdlb_des_rx
  import sdlb_pkg::*;
#(
  parameter int                DATA_W  = 8,
  parameter int                PRE_LEN = 8,
  parameter logic [PRE_LEN-1:0] PRE_PAT = 8'hB4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              vld,
  input  logic              bit_i,
  output logic              pre_pulse_o,
  output logic              perr_pulse_o,
  output logic [DATA_W-1:0] w1_o,
  output logic [DATA_W-1:0] w2_o
);

  localparam int W  = DATA_W + 1;
  localparam int DW = 2 * W;
  localparam int MX = (PRE_LEN > DW) ? PRE_LEN : DW;
  localparam int CW = $clog2(MX + 1);

  rx_st_e             st_q, st_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic [PRE_LEN-1:0] win_q, win_d, win_n;
  logic [DW-1:0]      dsr_q, dsr_d, dsr_n;
  logic [DATA_W-1:0]  w1_q, w1_d, w2_q, w2_d;
  logic               pre_q, pre_d;
  logic               perr_q, perr_d;
  logic               rx_en;

  assign win_n = {bit_i, win_q[PRE_LEN-1:1]};
  assign dsr_n = {bit_i, dsr_q[DW-1:1]};

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    win_d  = win_q;
    dsr_d  = dsr_q;
    w1_d   = w1_q;
    w2_d   = w2_q;
    pre_d  = 1'b0;
    perr_d = 1'b0;
    if (clr) begin
      st_d  = RX_HUNT;
      cnt_d = '0;
      win_d = '0;
      dsr_d = '0;
      w1_d  = '0;
      w2_d  = '0;
    end else if (vld) begin
      case (st_q)
        RX_HUNT: begin
          win_d = win_n;
          if (cnt_q != CW'(PRE_LEN)) begin
            cnt_d = cnt_q + 1'b1;
          end
          if ((cnt_q >= CW'(PRE_LEN - 1)) && (win_n == PRE_PAT)) begin
            st_d  = RX_DATA;
            cnt_d = '0;
            pre_d = 1'b1;
          end
        end
        RX_DATA: begin
          dsr_d = dsr_n;
          if (cnt_q == CW'(DW - 1)) begin
            st_d   = RX_DONE;
            cnt_d  = '0;
            w1_d   = dsr_n[DATA_W-1:0];
            w2_d   = dsr_n[W+DATA_W-1:W];
            perr_d = !(^dsr_n[W-1:0]) || !(^dsr_n[DW-1:W]);
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          st_d = RX_DONE;
        end
      endcase
    end
  end

  assign rx_en = clr || vld || pre_q || perr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_HUNT;
      cnt_q  <= '0;
      win_q  <= '0;
      dsr_q  <= '0;
      w1_q   <= '0;
      w2_q   <= '0;
      pre_q  <= 1'b0;
      perr_q <= 1'b0;
    end else if (rx_en) begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      win_q  <= win_d;
      dsr_q  <= dsr_d;
      w1_q   <= w1_d;
      w2_q   <= w2_d;
      pre_q  <= pre_d;
      perr_q <= perr_d;
    end
  end

  assign pre_pulse_o  = pre_q;
  assign perr_pulse_o = perr_q;
  assign w1_o         = w1_q;
  assign w2_o         = w2_q;

endmodule

// File: rtl/sdlb_diag.sv
`timescale 1ns/1ps
module sdlb_diag #(
  parameter int                DATA_W  = 8,
  parameter int                STB_GAP = 48,
  parameter int                PRE_LEN = 8,
  parameter logic [PRE_LEN-1:0] PRE_PAT = 8'hB4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            test_en,
  input  logic            sector_begin,
  input  logic [DATA_W:0] host_byte_i,
  output logic [3:0]      byte_stb_o,
  output logic [DATA_W:0] resp_byte_o,
  output logic            perr_ser_o,
  output logic            perr_des_o,
  output logic            perr_fx_o,
  output logic            preamble_o
);

  localparam int W    = DATA_W + 1;
  localparam int NSTB = 4;

  logic              rst_i_n;
  logic [NSTB-1:0]   stb;
  logic              loop_clr;
  logic [W-1:0]      w1_q, w1_d;
  logic              ser_vld, ser_bit, ser_pay;
  logic              ser_pls, des_pls, pre_pls;
  logic [DATA_W-1:0] rx_w1, rx_w2;
  logic [W-1:0]      rsp;
  logic              fx_q, fx_d;

  sdlb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  sdlb_strobe_seq #(
    .STB_GAP (STB_GAP),
    .NSTB    (NSTB)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_i_n),
    .run   (test_en),
    .start (sector_begin),
    .stb_o (stb)
  );

  // flush the loop on abort and at the start of every exchange
  assign loop_clr = !test_en || stb[0];

  // first stimulus byte held until the second arrives
  always_comb begin
    w1_d = w1_q;
    if (stb[0]) begin
      w1_d = host_byte_i;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      w1_q <= '0;
    end else if (stb[0]) begin
      w1_q <= w1_d;
    end
  end

  sdlb_ser_tx #(
    .DATA_W  (DATA_W),
    .PRE_LEN (PRE_LEN),
    .PRE_PAT (PRE_PAT)
  ) u_tx (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .clr     (loop_clr),
    .load    (stb[1]),
    .w1      (w1_q),
    .w2      (host_byte_i),
    .ser_vld (ser_vld),
    .ser_bit (ser_bit),
    .ser_pay (ser_pay)
  );

  sdlb_ser_par #(
    .W  (W),
    .NW (2)
  ) u_spar (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .clr         (loop_clr),
    .vld         (ser_vld),
    .pay         (ser_pay),
    .bit_i       (ser_bit),
    .err_pulse_o (ser_pls)
  );

  sdlb_des_rx #(
    .DATA_W  (DATA_W),
    .PRE_LEN (PRE_LEN),
    .PRE_PAT (PRE_PAT)
  ) u_rx (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .clr          (loop_clr),
    .vld          (ser_vld),
    .bit_i        (ser_bit),
    .pre_pulse_o  (pre_pls),
    .perr_pulse_o (des_pls),
    .w1_o         (rx_w1),
    .w2_o         (rx_w2)
  );

  // response path: parity bit forced to the even (wrong) value
  always_comb begin
    rsp = '0;
    if (stb[2]) begin
      rsp = {^rx_w1, rx_w1};
    end else if (stb[3]) begin
      rsp = {^rx_w2, rx_w2};
    end
  end

  // return-path odd-parity checker
  always_comb begin
    fx_d = test_en && (stb[2] || stb[3]) && !(^rsp);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      fx_q <= 1'b0;
    end else if (fx_q || fx_d) begin
      fx_q <= fx_d;
    end
  end

  assign byte_stb_o  = stb;
  assign resp_byte_o = test_en ? rsp : '0;
  assign perr_ser_o  = test_en && ser_pls;
  assign perr_des_o  = test_en && des_pls;
  assign perr_fx_o   = test_en && fx_q;
  assign preamble_o  = test_en && pre_pls;

endmodule

// File: rtl/sdlb_diag_chk.sv
`timescale 1ns/1ps
module sdlb_diag_chk #(
  parameter int STB_GAP = 48,
  parameter int W       = 9
) (
  input logic         clk,
  input logic         rst_n,
  input logic         test_en,
  input logic         sector_begin,
  input logic [3:0]   byte_stb_o,
  input logic [W-1:0] resp_byte_o,
  input logic         perr_ser_o,
  input logic         perr_des_o,
  input logic         perr_fx_o,
  input logic         preamble_o
);

  localparam int GW = $clog2(STB_GAP + 1);

  logic [GW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
    end else if (|byte_stb_o) begin
      since_q <= '0;
    end else if (since_q != GW'(STB_GAP)) begin
      since_q <= since_q + 1'b1;
    end
  end

  // R3
  stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(byte_stb_o));

  // R3
  stb_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|byte_stb_o[3:1]) |-> (since_q == GW'(STB_GAP - 1)));

  // R2
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb_o[0] |-> $past(sector_begin && test_en));

  // R5
  resp_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_byte_o != '0) |-> (byte_stb_o[2] || byte_stb_o[3]));

  // R5
  resp_forced_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb_o[2] || byte_stb_o[3]) |-> !(^resp_byte_o));

  // R6
  fx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb_o[2] || byte_stb_o[3]) |=> (perr_fx_o || !test_en));

  // R11
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |-> ((byte_stb_o == 4'b0) && (resp_byte_o == '0) && !perr_ser_o
                  && !perr_des_o && !perr_fx_o && !preamble_o));

endmodule

bind sdlb_diag sdlb_diag_chk #(
  .STB_GAP (STB_GAP),
  .W       (DATA_W + 1)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .test_en      (test_en),
  .sector_begin (sector_begin),
  .byte_stb_o   (byte_stb_o),
  .resp_byte_o  (resp_byte_o),
  .perr_ser_o   (perr_ser_o),
  .perr_des_o   (perr_des_o),
  .perr_fx_o    (perr_fx_o),
  .preamble_o   (preamble_o)
);

// File: tb/sdlb_diag_test.sv
`timescale 1ns/1ps
module sdlb_diag_test;

  localparam int GAP = 48;
  localparam int WIN = 3 * GAP + 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       test_en;
  logic       sector_begin;
  logic [8:0] host_byte;
  logic [3:0] byte_stb;
  logic [8:0] resp_byte;
  logic       perr_ser, perr_des, perr_fx, preamble;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  sdlb_diag #(
    .DATA_W  (8),
    .STB_GAP (GAP),
    .PRE_LEN (8),
    .PRE_PAT (8'hB4)
  ) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .test_en      (test_en),
    .sector_begin (sector_begin),
    .host_byte_i  (host_byte),
    .byte_stb_o   (byte_stb),
    .resp_byte_o  (resp_byte),
    .perr_ser_o   (perr_ser),
    .perr_des_o   (perr_des),
    .perr_fx_o    (perr_fx),
    .preamble_o   (preamble)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] mk_byte(input logic [7:0] d, input bit bad);
    return {(~(^d)) ^ bad, d};
  endfunction

  function automatic int outs_active();
    return int'(byte_stb != 0) + int'(resp_byte != 0) + int'(perr_ser) + int'(perr_des)
         + int'(perr_fx) + int'(preamble);
  endfunction

  // one full exchange starting at the next negedge
  task automatic run_x(input logic [7:0] d1, input bit b1, input logic [7:0] d2,
                       input bit b2, input bit mid_begin);
    int stb_err = 0;
    int last_act = 0;
    int last_exp = 0;
    int n_ser = 0, n_des = 0, n_pre = 0, n_fx = 0, late = 0, idle_rsp = 0;
    logic [8:0] exp3, exp4;
    exp3 = {^d1, d1};
    exp4 = {^d2, d2};
    @(negedge clk);
    test_en      = 1'b1;
    sector_begin = 1'b1;
    @(negedge clk);
    sector_begin = 1'b0;
    for (int i = 1; i <= WIN; i++) begin
      int k_exp;
      logic [3:0] e_stb;
      k_exp = -1;
      if (((i - 1) % GAP == 0) && ((i - 1) / GAP < 4)) k_exp = (i - 1) / GAP;
      e_stb = (k_exp >= 0) ? 4'(1 << k_exp) : 4'b0;
      if (byte_stb != e_stb) begin
        stb_err++;
        last_act = int'(byte_stb);
        last_exp = int'(e_stb);
      end
      if (byte_stb[2]) chk(resp_byte == exp3, "R4 R5 response byte 3", int'(resp_byte), int'(exp3));
      if (byte_stb[3]) chk(resp_byte == exp4, "R4 R5 response byte 4", int'(resp_byte), int'(exp4));
      if (!byte_stb[2] && !byte_stb[3] && resp_byte != 0) idle_rsp++;
      if (perr_ser) n_ser++;
      if (perr_des) n_des++;
      if (preamble) n_pre++;
      if (perr_fx) n_fx++;
      if ((perr_ser || perr_des || preamble) && (i >= 1 + 2 * GAP || i <= 1 + GAP)) late++;
      if (byte_stb[0])      host_byte = mk_byte(d1, b1);
      else if (byte_stb[1]) host_byte = mk_byte(d2, b2);
      else                  host_byte = 9'h1FF ^ 9'(i * 37);
      sector_begin = (mid_begin && (i == GAP / 2 || i == 2 * GAP + 3)) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    sector_begin = 1'b0;
    chk(stb_err == 0, "R3 strobe schedule", last_act, last_exp);
    if (mid_begin) chk(stb_err == 0, "R10 mid-exchange sector_begin ignored", last_act, last_exp);
    chk(idle_rsp == 0, "R5 response zero outside strobes 3/4", idle_rsp, 0);
    chk(n_fx == 2, "R6 forced parity pulses", n_fx, 2);
    chk(n_ser == int'(b1 | b2), "R7 serial parity pulse count", n_ser, int'(b1 | b2));
    chk(n_des == int'(b1 | b2), "R8 deserialised parity pulse count", n_des, int'(b1 | b2));
    chk(n_pre == 1, "R9 preamble pulse count", n_pre, 1);
    chk(late == 0, "R7 R8 R9 pulse between strobe 2 and 3", late, 0);
  endtask

  // watch a window with no exchange expected
  task automatic quiet_window(input int cycles, input string tag);
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (outs_active() != 0) bad++;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n        = 1'b0;
    test_en      = 1'b0;
    sector_begin = 1'b0;
    host_byte    = '0;
    repeat (4) @(negedge clk);
    // R1
    chk(outs_active() == 0, "R1 outputs low in reset", outs_active(), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(outs_active() == 0, "R1 outputs low after reset", outs_active(), 0);

    // R2: sector_begin while test_en low
    @(negedge clk);
    sector_begin = 1'b1;
    @(negedge clk);
    sector_begin = 1'b0;
    quiet_window(WIN, "R2 no exchange with test_en low");
    test_en = 1'b1;
    quiet_window(WIN, "R2 no exchange without sector_begin");

    // basic clean exchange
    run_x(8'h3C, 1'b0, 8'hC3, 1'b0, 1'b0);

    // R11: abort on the strobe-3 cycle
    begin
      int seen = 0;
      @(negedge clk);
      sector_begin = 1'b1;
      @(negedge clk);
      sector_begin = 1'b0;
      for (int i = 1; i <= 1 + 2 * GAP; i++) begin
        if (byte_stb[0]) host_byte = mk_byte(8'h81, 1'b0);
        if (byte_stb[1]) host_byte = mk_byte(8'h7E, 1'b0);
        if (i < 1 + 2 * GAP) @(negedge clk);
      end
      seen = int'(byte_stb);
      chk(byte_stb == 4'b0100, "R11 strobe 3 present before abort", seen, 4);
      test_en = 1'b0;
      #1;
      chk(outs_active() == 0, "R11 outputs cleared in abort cycle", outs_active(), 0);
      quiet_window(6, "R11 outputs held low while disabled");
      test_en = 1'b1;
      quiet_window(WIN, "R11 no strobes after abort until sector_begin");
    end

    // R11: abort mid serial stream, then a clean exchange must still work
    begin
      @(negedge clk);
      sector_begin = 1'b1;
      @(negedge clk);
      sector_begin = 1'b0;
      for (int i = 1; i <= 1 + GAP + 10; i++) begin
        if (byte_stb[0]) host_byte = mk_byte(8'hF0, 1'b1);
        if (byte_stb[1]) host_byte = mk_byte(8'h0F, 1'b0);
        @(negedge clk);
      end
      test_en = 1'b0;
      #1;
      chk(outs_active() == 0, "R11 outputs cleared mid-stream", outs_active(), 0);
      quiet_window(3, "R11 outputs held low mid-stream abort");
    end
    run_x(8'h55, 1'b0, 8'hAA, 1'b0, 1'b0);

    // near-exhaustive sweep of stimulus values and parity faults
    for (int v = 0; v < 256; v++) begin
      logic [7:0] a, b;
      a = 8'(v);
      b = {a[3:0], a[7:4]} ^ 8'h3C;
      run_x(a, a[0], b, a[1], (v % 37) == 5);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule